// File: doc/BRIEF.md
# RS-485 Automatic Driver-Direction Controller

This block owns the driver-enable (RTS) line of one UART when the port is wired to a half-duplex RS-485 transceiver. It watches two activity indications from the transmitter: the transmit FIFO holds data, and the shift register is still sending a character. From these it turns the bus driver on before the first bit leaves and turns it off once the line has gone quiet. Two optional guard intervals can be added, each four character times long and timed by a character-period tick. The pre-send guard holds the transmitter back after the driver comes on. The post-send guard keeps the driver on after the last stop bit.

The behaviour comes from a stored configuration byte with four meaningful fields: an enable, a polarity select and two guard enables. When the enable is clear, the pin simply reflects the modem-control RTS bit, as a plain UART would. The polarity of the pin is never written directly. A configuration write carries the requested pin level for sending and for idle, and a write that asks for the same level in both states is dropped. The guard enables only take effect on logical port 0; any other port index runs with both guards at zero. Besides the pin, the block gives a busy flag that is high while it owns the bus, and a transmit-permission output for the UART.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the busy flag is low, the transmit permission is high, and the RTS pin is high (default byte: all fields zero, idle level high).
- R2: While the enable bit (bit 4) of the stored byte is clear, the RTS pin equals the inverse of `mcr_rts`, busy stays low and transmit activity has no effect.
- R3: With the enable set and no guards, the pin moves to the send level one clock after activity appears (FIFO non-empty or shifter busy) and returns to the idle level one clock after both indications are clear.
- R4: Bit 5 of the stored byte selects polarity: 1 gives a high pin while sending and low while idle, 0 gives the reverse.
- R5: With the pre-send guard (bit 2) on port 0, the driver is asserted and transmit permission is held low until the fourth `char_tick` after activity starts; permission rises on the clock edge of that fourth tick.
- R6: With the post-send guard (bit 3) on port 0, the driver stays asserted after activity ends until the fourth `char_tick`, and is released on the clock edge of that tick.
- R7: Release does not start while the shifter is busy, even if the FIFO is empty.
- R8: New activity during the post-send guard cancels it; the driver stays asserted and the next end of activity starts a fresh four-tick guard.
- R9: On a port index other than 0, bits 2 and 3 are ignored and the block behaves as if neither guard is enabled.
- R10: A configuration write with `lvl_send` equal to `lvl_idle` is ignored and the stored byte is unchanged; an accepted write stores `cfg_wdata` with bit 5 replaced by `lvl_send`.
- R11: The busy flag is high exactly while the driver is asserted in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to store (bit 5 is taken from lvl_send) |
| lvl_send | input | 1 | Requested pin level while sending |
| lvl_idle | input | 1 | Requested pin level while idle |
| port_idx | input | 2 | Logical port index; guards are honoured only at 0 |
| mcr_rts | input | 1 | Modem-control RTS bit used when automatic mode is off |
| tx_fifo_nonempty | input | 1 | Transmit FIFO holds data |
| tx_shift_busy | input | 1 | Transmit shift register is sending |
| char_tick | input | 1 | One-cycle pulse per character time |
| rts_o | output | 1 | RTS / driver-enable pin |
| busy_o | output | 1 | High while the block owns the bus |
| tx_allow_o | output | 1 | Permission for the UART to start sending |

## Verification
A table walks polarity, enable and every combination of the two activity indications in steady state, which separates the pass-through path from the automatic path and shows that FIFO data and shifter activity each keep the driver on. Directed sequences then count ticks through both guards to tell a four-tick guard from a shorter or longer one. A burst arriving mid-guard shows whether the guard is cancelled and restarted or only paused. The same delayed configuration on port 1 shows that the port-index masking works, and an equal-level write shows that the rejection leaves the old behaviour in place.

// File: rtl/rs485_dir_pkg.sv
// Shared definitions for the RS-485 direction controller.
// Assumes the configuration byte is eight bits wide with the field
// positions below; a neighbouring register decoder relies on them.
package rs485_dir_pkg;
    localparam int CFG_W    = 8;
    localparam int BIT_PRE  = 2;   // pre-send guard enable
    localparam int BIT_POST = 3;   // post-send guard enable
    localparam int BIT_EN   = 4;   // automatic direction enable
    localparam int BIT_INV  = 5;   // pin high while sending

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_SEND = 2'd2,
        ST_POST = 2'd3
    } dir_state_e;
endpackage

// File: rtl/rs485_cfg_reg.sv
// Configuration store with the equal-level rejection rule.
// Holds the byte, drops writes whose send and idle levels match, and
// masks the guard enables unless the port index equals GUARD_PORT.
// Assumes cfg_we is a single-cycle strobe in the clk domain.
module rs485_cfg_reg
    import rs485_dir_pkg::*;
#(
    parameter int          IDX_W      = 2,
    parameter int          GUARD_PORT = 0,
    parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             lvl_send,
    input  logic             lvl_idle,
    input  logic [IDX_W-1:0] port_idx,
    output logic [CFG_W-1:0] cfg_q,
    output logic             en,
    output logic             inv,
    output logic             pre_en,
    output logic             post_en
);
    localparam logic [IDX_W-1:0] GUARD_IDX = IDX_W'(GUARD_PORT);

    logic             legal;
    logic [CFG_W-1:0] wr_byte;
    logic             guard_ok;

    // Build the byte to store: polarity comes from the requested send level.
    always_comb begin
        legal            = (lvl_send != lvl_idle);
        wr_byte          = cfg_wdata;
        wr_byte[BIT_INV] = lvl_send;
    end

    // Register the configuration; illegal writes leave it untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RESET_CFG;
        end else if (cfg_we && legal) begin
            cfg_q <= wr_byte;
        end
    end

    // Decode fields; guards only count on the guard-capable port.
    always_comb begin
        guard_ok = (port_idx == GUARD_IDX);
        en       = cfg_q[BIT_EN];
        inv      = cfg_q[BIT_INV];
        pre_en   = cfg_q[BIT_PRE]  & guard_ok;
        post_en  = cfg_q[BIT_POST] & guard_ok;
    end
endmodule

// File: rtl/rs485_guard_timer.sv
// Counts character ticks during a guard interval.
// done pulses on the tick that completes GUARD_CHARS ticks while run is
// high; the count clears whenever run is low, so each guard starts fresh.
// Assumes char_tick is a single-cycle pulse.
module rs485_guard_timer #(
    parameter int GUARD_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int            CNT_W = $clog2(GUARD_CHARS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GUARD_CHARS - 1);

    logic [CNT_W-1:0] cnt;

    // Terminal condition: last tick of the interval.
    always_comb begin
        done = run && tick && (cnt == LAST);
    end

    // Advance on each tick while running, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs485_dir_fsm.sv
// Direction sequencer: idle, pre-send guard, sending, post-send guard.
// Leaves idle on transmitter activity, returns through the optional
// post guard once activity is gone, and drops to idle when disabled.
// Assumes tx_active already merges FIFO and shifter indications.
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pre_en,
    input  logic       post_en,
    input  logic       tx_active,
    input  logic       guard_done,
    output dir_state_e state,
    output logic       guard_run,
    output logic       drive
);
    dir_state_e state_nx;

    // Next-state decision.
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (tx_active) state_nx = pre_en ? ST_PRE : ST_SEND;
                ST_PRE:  if (guard_done) state_nx = ST_SEND;
                ST_SEND: if (!tx_active) state_nx = post_en ? ST_POST : ST_IDLE;
                ST_POST: begin
                    if (tx_active)       state_nx = ST_SEND;
                    else if (guard_done) state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Guard timer runs in pre-send, and in post-send only while quiet.
    always_comb begin
        guard_run = (state == ST_PRE) || ((state == ST_POST) && !tx_active);
        drive     = (state != ST_IDLE);
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
// Top of the RS-485 automatic driver-direction controller.
// Combines the configuration store, the guard timer and the sequencer,
// and forms the RTS pin, the busy flag and the transmit permission.
// Assumes all inputs are synchronous to clk.
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int IDX_W       = 2,
    parameter int GUARD_PORT  = 0,
    parameter int GUARD_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             lvl_send,
    input  logic             lvl_idle,
    input  logic [IDX_W-1:0] port_idx,
    input  logic             mcr_rts,
    input  logic             tx_fifo_nonempty,
    input  logic             tx_shift_busy,
    input  logic             char_tick,
    output logic             rts_o,
    output logic             busy_o,
    output logic             tx_allow_o
);
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_en, cfg_inv, cfg_pre, cfg_post;
    logic             tx_active;
    logic             guard_run, guard_done, drive;
    dir_state_e       state;

    // Transmitter is active while data waits or a character is on the wire.
    always_comb begin
        tx_active = tx_fifo_nonempty | tx_shift_busy;
    end

    rs485_cfg_reg #(
        .IDX_W      (IDX_W),
        .GUARD_PORT (GUARD_PORT),
        .RESET_CFG  ('0)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .lvl_send  (lvl_send),
        .lvl_idle  (lvl_idle),
        .port_idx  (port_idx),
        .cfg_q     (cfg_q),
        .en        (cfg_en),
        .inv       (cfg_inv),
        .pre_en    (cfg_pre),
        .post_en   (cfg_post)
    );

    rs485_guard_timer #(
        .GUARD_CHARS (GUARD_CHARS)
    ) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (guard_run),
        .tick  (char_tick),
        .done  (guard_done)
    );

    rs485_dir_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .pre_en     (cfg_pre),
        .post_en    (cfg_post),
        .tx_active  (tx_active),
        .guard_done (guard_done),
        .state      (state),
        .guard_run  (guard_run),
        .drive      (drive)
    );

    // Pin and status forming: automatic mode versus modem-control pass-through.
    always_comb begin
        if (cfg_en) begin
            rts_o      = drive ? cfg_inv : ~cfg_inv;
            busy_o     = drive;
            tx_allow_o = (state == ST_SEND);
        end else begin
            rts_o      = ~mcr_rts;
            busy_o     = 1'b0;
            tx_allow_o = 1'b1;
        end
    end
endmodule

// File: rtl/rs485_dir_chk.sv
// Property checker for the direction controller, bound to the top.
// Observes ports plus the stored configuration byte.
module rs485_dir_chk
    import rs485_dir_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             lvl_send,
    input logic             lvl_idle,
    input logic             mcr_rts,
    input logic             tx_fifo_nonempty,
    input logic             tx_shift_busy,
    input logic             rts_o,
    input logic             busy_o,
    input logic             tx_allow_o,
    input logic [CFG_W-1:0] cfg_q
);
    // R2: pass-through when automatic mode is off
    a_r2_mcr_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[BIT_EN] |-> (rts_o == !mcr_rts) && !busy_o);

    // R3: activity while idle takes the bus on the next cycle
    a_r3_take_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[BIT_EN] && !busy_o && !cfg_we && (tx_fifo_nonempty || tx_shift_busy))
        |=> busy_o);

    // R8: the bus is never released while activity persists
    a_r8_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[BIT_EN] && busy_o && !cfg_we && (tx_fifo_nonempty || tx_shift_busy))
        |=> busy_o);

    // R5: in automatic mode the transmitter may start only while driving
    a_r5_tx_only_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[BIT_EN] && tx_allow_o) |-> busy_o);

    // R10: equal-level writes leave the stored byte unchanged
    a_r10_illegal_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (lvl_send == lvl_idle)) |=> $stable(cfg_q));

    // R11: driving level matches busy in automatic mode
    a_r11_busy_matches_pin: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[BIT_EN] |-> (busy_o == (rts_o == cfg_q[BIT_INV])));
endmodule

bind rs485_dir_ctrl rs485_dir_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .lvl_send         (lvl_send),
    .lvl_idle         (lvl_idle),
    .mcr_rts          (mcr_rts),
    .tx_fifo_nonempty (tx_fifo_nonempty),
    .tx_shift_busy    (tx_shift_busy),
    .rts_o            (rts_o),
    .busy_o           (busy_o),
    .tx_allow_o       (tx_allow_o),
    .cfg_q            (cfg_q)
);

// File: tb/rs485_dir_ctrl_bench.sv
// Self-checking bench: steady-state vector table, then directed guard,
// cancellation, port-index and rejection sequences.
module rs485_dir_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;
    // vector: {en, inv, mcr, fifo, shift, exp_rts, exp_busy}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_0_0_0_0_1_0,
        7'b0_0_1_1_1_0_0,
        7'b0_1_0_1_0_1_0,
        7'b1_0_0_0_0_1_0,
        7'b1_0_1_1_0_0_1,
        7'b1_0_0_0_1_0_1,
        7'b1_1_0_0_0_0_0,
        7'b1_1_0_1_1_1_1,
        7'b1_1_1_0_0_0_0,
        7'b0_1_1_0_0_0_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       lvl_send = 1'b0, lvl_idle = 1'b1;
    logic [1:0] port_idx = '0;
    logic       mcr_rts = 1'b0;
    logic       fifo = 1'b0, shift = 1'b0, tick = 1'b0;
    logic       rts_o, busy_o, tx_allow_o;
    int         n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_dir_ctrl u_rs485_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .lvl_send(lvl_send), .lvl_idle(lvl_idle), .port_idx(port_idx),
        .mcr_rts(mcr_rts), .tx_fifo_nonempty(fifo), .tx_shift_busy(shift),
        .char_tick(tick), .rts_o(rts_o), .busy_o(busy_o), .tx_allow_o(tx_allow_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Legal write: byte {inv at 5, en at 4, post at 3, pre at 2}
    task automatic write_cfg(input logic en, input logic inv, input logic post, input logic pre);
        cfg_we    = 1'b1;
        cfg_wdata = {2'b00, inv, en, post, pre, 2'b00};
        lvl_send  = inv;
        lvl_idle  = ~inv;
        step();
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 rts", rts_o, 1'b1);
        chk("R1 busy", busy_o, 1'b0);
        chk("R1 tx_allow", tx_allow_o, 1'b1);

        // Table walk: R2 pass-through, R3 no-guard timing, R4 polarity, R11 busy
        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VEC[i][6], VEC[i][5], 1'b0, 1'b0);
            mcr_rts = VEC[i][4];
            fifo    = VEC[i][3];
            shift   = VEC[i][2];
            step();
            chk(VEC[i][6] ? "R4 rts" : "R2 rts", rts_o, VEC[i][1]);
            chk(VEC[i][6] ? "R11 busy" : "R2 busy", busy_o, VEC[i][0]);
        end
        fifo = 1'b0; shift = 1'b0; mcr_rts = 1'b0;
        step();

        // R5 pre-send guard, inv=1
        write_cfg(1'b1, 1'b1, 1'b0, 1'b1);
        fifo = 1'b1;
        step();
        chk("R5 rts asserted", rts_o, 1'b1);
        chk("R5 tx held", tx_allow_o, 1'b0);
        for (int t = 0; t < 3; t++) pulse_tick();
        chk("R5 still held after 3 ticks", tx_allow_o, 1'b0);
        pulse_tick();
        chk("R5 released on 4th tick", tx_allow_o, 1'b1);
        fifo = 1'b0;
        step();
        chk("R3 release without post guard", rts_o, 1'b0);

        // R6/R7 post-send guard, inv=0
        write_cfg(1'b1, 1'b0, 1'b1, 1'b0);
        fifo = 1'b1;
        step();
        chk("R3 send level", rts_o, 1'b0);
        fifo = 1'b0; shift = 1'b1;
        step();
        pulse_tick();
        chk("R7 held while shifter busy", rts_o, 1'b0);
        shift = 1'b0;
        step();
        for (int t = 0; t < 3; t++) pulse_tick();
        chk("R6 held after 3 ticks", rts_o, 1'b0);
        chk("R6 busy after 3 ticks", busy_o, 1'b1);
        pulse_tick();
        chk("R6 released on 4th tick", rts_o, 1'b1);
        chk("R6 busy clear", busy_o, 1'b0);

        // R8 cancel post guard and restart
        fifo = 1'b1;
        step();
        fifo = 1'b0;
        step();
        pulse_tick();
        pulse_tick();
        fifo = 1'b1;
        step();
        chk("R8 still asserted on new data", rts_o, 1'b0);
        fifo = 1'b0;
        step();
        for (int t = 0; t < 3; t++) pulse_tick();
        chk("R8 fresh guard after 3 ticks", busy_o, 1'b1);
        pulse_tick();
        chk("R8 release after fresh guard", busy_o, 1'b0);

        // R9 port index 1 ignores both guards
        port_idx = 2'd1;
        write_cfg(1'b1, 1'b1, 1'b1, 1'b1);
        fifo = 1'b1;
        step();
        chk("R9 no pre guard", tx_allow_o, 1'b1);
        fifo = 1'b0;
        step();
        chk("R9 no post guard", busy_o, 1'b0);
        chk("R9 idle level", rts_o, 1'b0);
        port_idx = 2'd0;

        // R10 illegal write (levels equal, enable clear) is dropped
        write_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        cfg_we = 1'b1; cfg_wdata = 8'h00; lvl_send = 1'b0; lvl_idle = 1'b0;
        mcr_rts = 1'b1;
        step();
        cfg_we = 1'b0;
        fifo = 1'b1;
        step();
        chk("R10 busy kept", busy_o, 1'b1);
        chk("R10 polarity kept", rts_o, 1'b1);
        fifo = 1'b0;
        step();
        chk("R10 idle level kept", rts_o, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule